// File: doc/BRIEF.md
# Register Zero-Flag Shadow Bank

This block keeps, for every general register, a five-bit summary of which parts of its 64-bit value hold nonzero data. The issue logic can then ask whether a register is zero with one small lookup instead of reading and reducing the full word. The word is split into five slices of unequal width: two narrow 8-bit slices at the bottom and three 16-bit slices above them. Each slice has one flag, and that flag is 1 when any bit of that slice is set.

Two writeback ports update the summaries. Each port carries a register index, the 64-bit result and a five-bit slice mask. A slice flag changes only when its mask bit is set. One read port returns a single condition bit that is the OR of the addressed register's five flags. A reader that is stalled on a result must see that result in the same cycle it is written back. For this reason the read path forwards the flags being written, through per-slice multiplexers placed in front of edge-triggered storage. Register index 0 is a constant zero: it has no storage, it always reads as zero, and writes to it are dropped.

Top module: `zflag_bank`

## Requirements
- R1: An active-high synchronous reset clears every stored flag, so after reset every register index reads `rdNonZero` = 0.
- R2: A slice flag is the OR of the data bits inside that slice. Mask bit 0 selects bits [7:0], bit 1 selects [15:8], bit 2 selects [31:16], bit 3 selects [47:32] and bit 4 selects [63:48].
- R3: A slice whose mask bit is clear keeps its previous flag, whatever data the port carries.
- R4: `rdNonZero` is the OR of the five flags of the register named by `rdIdx`.
- R5: Index 0 always reads `rdNonZero` = 0, and writes that name index 0 change nothing.
- R6: When both write ports name the same register in one cycle, port 1 sets each slice that both masks enable, and each port alone sets the slices that only its own mask enables.
- R7: `rdNonZero` is combinational. During a cycle in which a port writes the register being read, it already shows the new flags for the enabled slices and the stored flags for the other slices.
- R8: Two writes to different nonzero registers in the same cycle both take effect.
- R9: After the clock edge that ends a write, the stored flags equal the values that the bypass showed during that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr0Idx | input | 6 | Write port 0 register index |
| wr0Data | input | 64 | Write port 0 result data |
| wr0Mask | input | 5 | Write port 0 slice mask |
| wr1Idx | input | 6 | Write port 1 register index (has priority) |
| wr1Data | input | 64 | Write port 1 result data |
| wr1Mask | input | 5 | Write port 1 slice mask |
| rdIdx | input | 6 | Read register index |
| rdNonZero | output | 1 | 1 when the addressed register holds nonzero data |

## Verification
The bench places single set bits on every slice boundary, with each mask enabled in turn. A design that maps a slice to the wrong bits would report a register as zero when its value is nonzero, or report nonzero data that was never written. It writes zeros under partial masks: a design that ignored the mask would clear flags it should keep. It also aims both ports at one register with overlapping and disjoint masks, so a reversed priority or a lost non-overlapping slice shows up as a wrong condition bit. Read checks are made before the clock edge in every cycle, with the two write ports randomly hitting the read index, so a design without forwarding shows the stale value. Index 0 is written with all-ones data, and it must still read zero.

// File: rtl/zflag_pkg.sv
package zflag_pkg;

  localparam int DATA_W     = 64;
  localparam int NUM_SLICES = 5;
  localparam int NUM_REGS   = 64;
  localparam int IDX_W      = $clog2(NUM_REGS);

  // Lowest bit of each slice; the slices are contiguous and ordered upward.
  function automatic int sliceLo(input int s);
    case (s)
      0:       return 0;
      1:       return 8;
      2:       return 16;
      3:       return 32;
      default: return 48;
    endcase
  endfunction

  function automatic int sliceHi(input int s);
    return (s == NUM_SLICES - 1) ? DATA_W - 1 : sliceLo(s + 1) - 1;
  endfunction

  // Reduce a data word to per-slice nonzero flags.
  function automatic logic [NUM_SLICES-1:0] sliceFlags(input logic [DATA_W-1:0] d);
    logic [NUM_SLICES-1:0] f;
    f = '0;
    for (int s = 0; s < NUM_SLICES; s++) begin
      for (int b = 0; b < DATA_W; b++) begin
        if (b >= sliceLo(s) && b <= sliceHi(s)) f[s] = f[s] | d[b];
      end
    end
    return f;
  endfunction

  // Strobes from control to datapath: effective per-port slice enables.
  typedef struct packed {
    logic [IDX_W-1:0]      idx0;
    logic [NUM_SLICES-1:0] en0;
    logic [IDX_W-1:0]      idx1;
    logic [NUM_SLICES-1:0] en1;
  } wrStrobes_t;

endpackage

// File: rtl/zflag_ctrl.sv
module zflag_ctrl
  import zflag_pkg::*;
(
  input  logic [IDX_W-1:0]      wr0Idx,
  input  logic [NUM_SLICES-1:0] wr0Mask,
  input  logic [IDX_W-1:0]      wr1Idx,
  input  logic [NUM_SLICES-1:0] wr1Mask,
  output wrStrobes_t            strobes
);

  logic wr0Live;
  logic wr1Live;
  logic sameTarget;

  assign wr0Live    = (wr0Idx != '0);
  assign wr1Live    = (wr1Idx != '0);
  assign sameTarget = (wr0Idx == wr1Idx);

  always_comb begin
    strobes.idx0 = wr0Idx;
    strobes.idx1 = wr1Idx;
    strobes.en1  = wr1Live ? wr1Mask : '0;
    strobes.en0  = wr0Live ? wr0Mask : '0;
    // Port 1 owns every slice both ports enable on a shared target.
    if (sameTarget) strobes.en0 = strobes.en0 & ~strobes.en1;
  end

endmodule

// File: rtl/zflag_slice_reduce.sv
module zflag_slice_reduce
  import zflag_pkg::*;
(
  input  logic [DATA_W-1:0]     data,
  output logic [NUM_SLICES-1:0] flags
);

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    assign flags[s] = |data[sliceHi(s):sliceLo(s)];
  end

endmodule

// File: rtl/zflag_datapath.sv
module zflag_datapath
  import zflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wrStrobes_t        strobes,
  input  logic [DATA_W-1:0] wr0Data,
  input  logic [DATA_W-1:0] wr1Data,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              rdNonZero
);

  logic [NUM_SLICES-1:0] flags0;
  logic [NUM_SLICES-1:0] flags1;
  logic [NUM_REGS-1:0][NUM_SLICES-1:0] shadow;
  logic [NUM_SLICES-1:0] rdFlags;

  zflag_slice_reduce i_reduce0 (.data(wr0Data), .flags(flags0));
  zflag_slice_reduce i_reduce1 (.data(wr1Data), .flags(flags1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
    end else begin
      shadow[0] <= '0;
      for (int r = 1; r < NUM_REGS; r++) begin
        for (int s = 0; s < NUM_SLICES; s++) begin
          if (strobes.idx1 == IDX_W'(r) && strobes.en1[s])
            shadow[r][s] <= flags1[s];
          else if (strobes.idx0 == IDX_W'(r) && strobes.en0[s])
            shadow[r][s] <= flags0[s];
        end
      end
    end
  end

  // Same-cycle forwarding: per-slice mux, port 1 applied last.
  always_comb begin
    rdFlags = shadow[rdIdx];
    for (int s = 0; s < NUM_SLICES; s++) begin
      if (strobes.idx0 == rdIdx && strobes.en0[s]) rdFlags[s] = flags0[s];
      if (strobes.idx1 == rdIdx && strobes.en1[s]) rdFlags[s] = flags1[s];
    end
    rdNonZero = (rdIdx != '0) && (|rdFlags);
  end

endmodule

// File: rtl/zflag_bank.sv
module zflag_bank
  import zflag_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IDX_W-1:0]      wr0Idx,
  input  logic [DATA_W-1:0]     wr0Data,
  input  logic [NUM_SLICES-1:0] wr0Mask,
  input  logic [IDX_W-1:0]      wr1Idx,
  input  logic [DATA_W-1:0]     wr1Data,
  input  logic [NUM_SLICES-1:0] wr1Mask,
  input  logic [IDX_W-1:0]      rdIdx,
  output logic                  rdNonZero
);

  wrStrobes_t strobes;

  zflag_ctrl i_ctrl (
    .wr0Idx (wr0Idx),
    .wr0Mask(wr0Mask),
    .wr1Idx (wr1Idx),
    .wr1Mask(wr1Mask),
    .strobes(strobes)
  );

  zflag_datapath i_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .wr0Data  (wr0Data),
    .wr1Data  (wr1Data),
    .rdIdx    (rdIdx),
    .rdNonZero(rdNonZero)
  );

endmodule

// File: rtl/zflag_bank_chk.sv
module zflag_bank_chk
  import zflag_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic [IDX_W-1:0]      wr0Idx,
  input logic [DATA_W-1:0]     wr0Data,
  input logic [NUM_SLICES-1:0] wr0Mask,
  input logic [IDX_W-1:0]      wr1Idx,
  input logic [DATA_W-1:0]     wr1Data,
  input logic [NUM_SLICES-1:0] wr1Mask,
  input logic [IDX_W-1:0]      rdIdx,
  input logic                  rdNonZero
);

  logic hitRead;
  assign hitRead = (wr0Idx == rdIdx && wr0Mask != '0) || (wr1Idx == rdIdx && wr1Mask != '0);

  // R1: the cycle after reset, with no writes, every register reads zero.
  p_reset_clear_r1: assert property (@(posedge clk)
    ($past(rst) && !rst && wr0Mask == '0 && wr1Mask == '0) |-> !rdNonZero);

  // R5: index 0 never reports nonzero.
  p_zero_index_r5: assert property (@(posedge clk) disable iff (rst)
    (rdIdx == '0) |-> !rdNonZero);

  // R7: a port-1 write of nonzero slice data to the read target shows at once.
  p_bypass_r7: assert property (@(posedge clk) disable iff (rst)
    (rdIdx != '0 && wr1Idx == rdIdx && |(wr1Mask & sliceFlags(wr1Data))) |-> rdNonZero);

  // R3: with no write touching the read target, the condition bit holds.
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rdIdx == $past(rdIdx) && !hitRead && !$past(hitRead))
      |-> rdNonZero == $past(rdNonZero));

  // R9: a full-mask port-1 write persists past its edge.
  p_persist_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rdIdx) != '0 && $past(wr1Idx) == $past(rdIdx) &&
     $past(wr1Mask) == '1 && rdIdx == $past(rdIdx) && !hitRead)
      |-> rdNonZero == |$past(wr1Data));

endmodule

bind zflag_bank zflag_bank_chk i_chk (.*);

// File: tb/test_zflag_bank.sv
`timescale 1ns/1ps
module test_zflag_bank;
  import zflag_pkg::*;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [IDX_W-1:0]      wr0Idx = '0;
  logic [DATA_W-1:0]     wr0Data = '0;
  logic [NUM_SLICES-1:0] wr0Mask = '0;
  logic [IDX_W-1:0]      wr1Idx = '0;
  logic [DATA_W-1:0]     wr1Data = '0;
  logic [NUM_SLICES-1:0] wr1Mask = '0;
  logic [IDX_W-1:0]      rdIdx = '0;
  logic                  rdNonZero;

  int checks = 0;
  int fails  = 0;
  logic [NUM_SLICES-1:0] model [NUM_REGS];

  always #5 clk = ~clk;

  zflag_bank i_zflag_bank (.*);

  // Slice boundaries from R2, written independently of the RTL.
  function automatic logic [NUM_SLICES-1:0] refFlags(input logic [63:0] d);
    return {|d[63:48], |d[47:32], |d[31:16], |d[15:8], |d[7:0]};
  endfunction

  function automatic logic expectRead();
    logic [NUM_SLICES-1:0] f;
    logic [NUM_SLICES-1:0] f0;
    logic [NUM_SLICES-1:0] f1;
    if (rdIdx == 0) return 1'b0;
    f  = model[rdIdx];
    f0 = refFlags(wr0Data);
    f1 = refFlags(wr1Data);
    for (int s = 0; s < NUM_SLICES; s++) begin
      if (wr0Idx == rdIdx && wr0Mask[s]) f[s] = f0[s];
      if (wr1Idx == rdIdx && wr1Mask[s]) f[s] = f1[s];
    end
    return |f;
  endfunction

  task automatic commitModel();
    logic [NUM_SLICES-1:0] f0;
    logic [NUM_SLICES-1:0] f1;
    f0 = refFlags(wr0Data);
    f1 = refFlags(wr1Data);
    if (wr0Idx != 0)
      for (int s = 0; s < NUM_SLICES; s++) if (wr0Mask[s]) model[wr0Idx][s] = f0[s];
    if (wr1Idx != 0)
      for (int s = 0; s < NUM_SLICES; s++) if (wr1Mask[s]) model[wr1Idx][s] = f1[s];
  endtask

  task automatic check(input string tag, input logic exp);
    checks++;
    if (rdNonZero !== exp) begin
      fails++;
      $display("FAIL %s rdIdx=%0d actual=%b expected=%b", tag, rdIdx, rdNonZero, exp);
    end
  endtask

  // Inputs are driven at the falling edge; the read is checked 1 ns later, and then the edge commits.
  task automatic step(input string tag,
                      input logic [5:0] i0, input logic [63:0] d0, input logic [4:0] m0,
                      input logic [5:0] i1, input logic [63:0] d1, input logic [4:0] m1,
                      input logic [5:0] ri, input logic doCheck);
    wr0Idx = i0; wr0Data = d0; wr0Mask = m0;
    wr1Idx = i1; wr1Data = d1; wr1Mask = m1;
    rdIdx = ri;
    #1;
    if (doCheck) check(tag, expectRead());
    @(posedge clk);
    commitModel();
    @(negedge clk);
  endtask

  task automatic readOnly(input string tag, input logic [5:0] ri, input logic exp);
    wr0Mask = '0; wr1Mask = '0; rdIdx = ri;
    #1;
    check(tag, exp);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] sparseData();
    logic [63:0] d;
    logic [4:0]  keep;
    d    = {$urandom, $urandom};
    keep = 5'($urandom);
    if (!keep[0]) d[7:0]   = '0;
    if (!keep[1]) d[15:8]  = '0;
    if (!keep[2]) d[31:16] = '0;
    if (!keep[3]) d[47:32] = '0;
    if (!keep[4]) d[63:48] = '0;
    return d;
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int bounds [10] = '{0, 7, 8, 15, 16, 31, 32, 47, 48, 63};
    void'($urandom(32'd20240611));
    for (int r = 0; r < NUM_REGS; r++) model[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: every index reads zero after reset.
    for (int r = 0; r < NUM_REGS; r++) readOnly("R1", 6'(r), 1'b0);

    // R2: single set bits at slice edges, owning slice enabled vs other slices only.
    foreach (bounds[k]) begin
      int b;
      int s;
      logic [63:0] d;
      b = bounds[k];
      s = (b < 8) ? 0 : (b < 16) ? 1 : (b < 32) ? 2 : (b < 48) ? 3 : 4;
      d = 64'd1 << b;
      step("R2", 6'd0, '0, '0, 6'd9, d, ~(5'd1 << s), 6'd9, 1'b1);
      readOnly("R2", 6'd9, 1'b0);
      step("R2", 6'd0, '0, '0, 6'd9, d, 5'd1 << s, 6'd9, 1'b1);
      readOnly("R2", 6'd9, 1'b1);
      step("R2", 6'd0, '0, '0, 6'd9, '0, 5'h1F, 6'd9, 1'b1);
    end

    // R3: masked-off slices keep their flag.
    step("R3", 6'd12, 64'h0000_0000_0100_0000, 5'h1F, 6'd0, '0, '0, 6'd12, 1'b1);
    step("R3", 6'd12, '0, 5'b11011, 6'd0, '0, '0, 6'd12, 1'b1);
    readOnly("R3", 6'd12, 1'b1);
    step("R3", 6'd12, '0, 5'b00100, 6'd0, '0, '0, 6'd12, 1'b1);
    readOnly("R3", 6'd12, 1'b0);

    // R4: a flag in the top slice alone is enough.
    step("R4", 6'd20, 64'h8000_0000_0000_0000, 5'h10, 6'd0, '0, '0, 6'd20, 1'b1);
    readOnly("R4", 6'd20, 1'b1);

    // R5: writes to index 0 are dropped and it reads zero.
    step("R5", 6'd0, '1, 5'h1F, 6'd0, '1, 5'h1F, 6'd0, 1'b1);
    readOnly("R5", 6'd0, 1'b0);

    // R6: overlapping slice, port 1 zero beats port 0 nonzero.
    step("R6", 6'd30, 64'hFF, 5'h01, 6'd30, 64'h0, 5'h01, 6'd30, 1'b1);
    readOnly("R6", 6'd30, 1'b0);
    // R6: disjoint slices from each port both land.
    step("R6", 6'd31, 64'hFF, 5'h01, 6'd31, 64'h0, 5'h02, 6'd31, 1'b1);
    readOnly("R6", 6'd31, 1'b1);
    step("R6", 6'd31, 64'h0, 5'h01, 6'd31, 64'hFF00, 5'h03, 6'd31, 1'b1);
    readOnly("R6", 6'd31, 1'b1);

    // R7: forwarding clears a nonzero register within the write cycle.
    step("R7", 6'd31, 64'h0, 5'h1F, 6'd0, '0, '0, 6'd31, 1'b1);

    // R8: both ports, different registers.
    step("R8", 6'd40, 64'h1, 5'h01, 6'd41, 64'h1_0000_0000, 5'h08, 6'd40, 1'b1);
    readOnly("R8", 6'd40, 1'b1);
    readOnly("R8", 6'd41, 1'b1);

    // R7 / R9: random traffic on a few registers to force collisions.
    for (int n = 0; n < 4000; n++) begin
      step("R7/R9",
           6'($urandom_range(0, 7)), sparseData(), 5'($urandom),
           6'($urandom_range(0, 7)), sparseData(), 5'($urandom),
           6'($urandom_range(0, 7)), 1'b1);
    end
    for (int r = 0; r < 8; r++) readOnly("R9", 6'(r), |model[r]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule